// File: doc/BRIEF.md
# Pause Flow-Control State Tracker

This block holds the flow-control state of an Ethernet MAC that uses IEEE pause frames. One shared pause timer is loaded by each pause event that carries a 16-bit quanta value. The timer counts down on a tick. Three status flags report the link's pause condition: a general "paused" flag, a "paused by a low-priority pause" flag and a "full" flag. The full flag means that this end has sent a pause. Each flag has its own set events and its own clear rule.

A software-controlled transmit-off request sits next to the flags. Writing one to its bit forces the request high, which the rest of the MAC treats as a full receive FIFO extender. Only a one written to a separate transmit-on bit of the same word drops it. A descriptor that asks for transmit-off also sets it.

All state is registered. An event seen at a rising clock edge is visible in the status word just after that edge. Frame parsing, pause-frame generation and the FIFO itself live in neighbouring blocks, which drive the event pulses.

Top module: `pause_fc_tracker`

## Requirements
- R1: After reset the status word is 0000h and `xoff_req` is 0.
- R2: Status bits 15:13 and 8:0 always read zero. A register write changes nothing except through bit 9 (transmit-off set) and bit 8 (transmit-on clear).
- R3: The pause timer loads on a received pause, a received pause-low or a transmitted pause. When several of these arrive in one cycle it takes the largest value. A load takes priority over a tick. With no load, the timer drops by one on each tick while nonzero and otherwise holds.
- R4: A zero-reached event occurs in the cycle where the timer goes from nonzero to zero. This happens either on a tick at value 1 or on a load of value 0.
- R5: Bit 12 (paused-low) sets when a pause-low command with a nonzero value is received. A pause-low command of value 0 does not set it. It clears on a zero-reached event or on a received pause command.
- R6: Bit 11 (paused) sets on a received pause, a received pause-low, the FIFO threshold being reached, a descriptor transmit-off request or a software transmit-off write. It clears only on a zero-reached event.
- R7: Bit 10 (full) sets when a pause with a nonzero value is transmitted and clears on a zero-reached event. A transmitted pause of value 0 does not set it.
- R8: Bit 9 (transmit-off) sets on a write with data bit 9 = 1 or on a descriptor transmit-off request. It clears only on a write with data bit 8 = 1. `xoff_req` equals bit 9.
- R9: When a set event and a clear event for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pause_vld | input | 1 | Pulse: pause command received |
| rx_pause_val | input | 16 | Quanta of the received pause |
| rx_plow_vld | input | 1 | Pulse: pause-low command received |
| rx_plow_val | input | 16 | Quanta of the received pause-low |
| tx_pause_vld | input | 1 | Pulse: pause command transmitted |
| tx_pause_val | input | 16 | Quanta of the transmitted pause |
| fifo_thresh_hit | input | 1 | Pulse: receive FIFO reached its threshold |
| desc_xoff_req | input | 1 | Pulse: fetched descriptor asks for transmit-off |
| tmr_tick | input | 1 | Pause-timer count enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Register write data |
| status_word | output | 16 | Flow-control status word |
| xoff_req | output | 1 | Transmit-off request |

## Verification
The bench targets three corner cases: a set and a clear landing on the same edge, several timer loads in one cycle, and a zero-valued load cutting a running count short. A design that let clear win would drop "paused" when a threshold hit arrives on the final tick. A design with a fixed load priority would release "full" too early when a short receive pause and a longer transmit pause arrive together. The bench also writes the transmit-off bit back to zero and writes every read-only bit, checking that neither changes the state. It also checks that zero-valued pause-low and transmit pauses leave their flags clear. A long random run is compared against a behavioural model on every clock.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // Bit positions that neighbouring software decodes; the four flags are contiguous.
  localparam int XON_BIT   = 8;
  localparam int FLAG_BASE = 9;
  localparam int NFLAG     = 4;
  localparam int FL_XOFF   = 0;
  localparam int FL_FULL   = 1;
  localparam int FL_PAUSED = 2;
  localparam int FL_PLOW   = 3;
  // Timer load sources
  localparam int NSRC      = 3;
  localparam int SRC_RXP   = 0;
  localparam int SRC_RXL   = 1;
  localparam int SRC_TXP   = 2;
endpackage

// File: rtl/pfc_timer.sv
module pfc_timer #(
  parameter int W    = 16,
  parameter int NSRC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         ld_vld,
  input  logic [NSRC-1:0][W-1:0]  ld_val,
  input  logic                    tick,
  output logic [W-1:0]            cnt,
  output logic                    zero_evt
);

  // Largest value among the sources loading this cycle.
  function automatic logic [W-1:0] pick_max(input logic [NSRC-1:0] v,
                                            input logic [NSRC-1:0][W-1:0] d);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (v[i] && (d[i] > m)) m = d[i];
    end
    return m;
  endfunction

  logic [W-1:0] cnt_q, cnt_d;
  logic         any_ld;

  assign any_ld = |ld_vld;

  always_comb begin
    if (any_ld)                    cnt_d = pick_max(ld_vld, ld_val);
    else if (tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_evt = (cnt_q != '0) && (cnt_d == '0);
  assign cnt      = cnt_q;

  assert_tick_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_ld) |=> $stable(cnt_q));

  assert_zero_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt_q == '0));

endmodule

// File: rtl/pfc_flag.sv
module pfc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(q));

endmodule

// File: rtl/pause_fc_tracker.sv
module pause_fc_tracker
  import pfc_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pause_vld,
  input  logic [VAL_W-1:0]  rx_pause_val,
  input  logic              rx_plow_vld,
  input  logic [VAL_W-1:0]  rx_plow_val,
  input  logic              tx_pause_vld,
  input  logic [VAL_W-1:0]  tx_pause_val,
  input  logic              fifo_thresh_hit,
  input  logic              desc_xoff_req,
  input  logic              tmr_tick,
  input  logic              reg_wr_en,
  input  logic [STAT_W-1:0] reg_wr_data,
  output logic [STAT_W-1:0] status_word,
  output logic              xoff_req
);

  // Named internal events, visible to the assertions below.
  logic                        sw_xoff, sw_xon, zero_evt;
  logic [NSRC-1:0]             ld_vld;
  logic [NSRC-1:0][VAL_W-1:0]  ld_val;
  logic [VAL_W-1:0]            tmr_cnt;
  logic [NFLAG-1:0]            flag_set, flag_clr, flag_q;

  assign sw_xoff = reg_wr_en & reg_wr_data[FLAG_BASE + FL_XOFF];
  assign sw_xon  = reg_wr_en & reg_wr_data[XON_BIT];

  always_comb begin
    ld_vld[SRC_RXP] = rx_pause_vld;
    ld_vld[SRC_RXL] = rx_plow_vld;
    ld_vld[SRC_TXP] = tx_pause_vld;
    ld_val[SRC_RXP] = rx_pause_val;
    ld_val[SRC_RXL] = rx_plow_val;
    ld_val[SRC_TXP] = tx_pause_val;
  end

  pfc_timer #(.W(VAL_W), .NSRC(NSRC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_vld   (ld_vld),
    .ld_val   (ld_val),
    .tick     (tmr_tick),
    .cnt      (tmr_cnt),
    .zero_evt (zero_evt)
  );

  // Per-flag set and clear sources.
  always_comb begin
    flag_set[FL_XOFF]   = sw_xoff | desc_xoff_req;
    flag_clr[FL_XOFF]   = sw_xon;
    flag_set[FL_FULL]   = tx_pause_vld & (|tx_pause_val);
    flag_clr[FL_FULL]   = zero_evt;
    flag_set[FL_PAUSED] = rx_pause_vld | rx_plow_vld | fifo_thresh_hit
                        | desc_xoff_req | sw_xoff;
    flag_clr[FL_PAUSED] = zero_evt;
    flag_set[FL_PLOW]   = rx_plow_vld & (|rx_plow_val);
    flag_clr[FL_PLOW]   = zero_evt | rx_pause_vld;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    pfc_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (flag_clr[g]),
      .q     (flag_q[g])
    );
  end

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NFLAG; i++) status_word[FLAG_BASE + i] = flag_q[i];
  end

  assign xoff_req = flag_q[FL_XOFF];

  assert_xoff_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff_req) |-> $past(sw_xon));

  assert_plow_in_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[FLAG_BASE + FL_PLOW] |-> status_word[FLAG_BASE + FL_PAUSED]);

  assert_full_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_word[FLAG_BASE + FL_FULL]) |-> $past(zero_evt));

  assert_timer_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[FLAG_BASE + FL_FULL] && tmr_cnt == '0) |-> $past(tx_pause_vld));

endmodule

// File: tb/pause_fc_tracker_bench.sv
module pause_fc_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pause_vld = 0, rx_plow_vld = 0, tx_pause_vld = 0;
  logic [15:0] rx_pause_val = 0, rx_plow_val = 0, tx_pause_val = 0;
  logic        fifo_thresh_hit = 0, desc_xoff_req = 0, tmr_tick = 0;
  logic        reg_wr_en = 0;
  logic [15:0] reg_wr_data = 0;
  logic [15:0] status_word;
  logic        xoff_req;

  int total = 0;
  int bad = 0;

  // Behavioural reference state
  int m_tmr = 0;
  bit m_plow = 0, m_paused = 0, m_full = 0, m_xoff = 0;

  always #10 clk = ~clk;

  pause_fc_tracker u_pause_fc_tracker (
    .clk(clk), .rst_n(rst_n),
    .rx_pause_vld(rx_pause_vld), .rx_pause_val(rx_pause_val),
    .rx_plow_vld(rx_plow_vld), .rx_plow_val(rx_plow_val),
    .tx_pause_vld(tx_pause_vld), .tx_pause_val(tx_pause_val),
    .fifo_thresh_hit(fifo_thresh_hit), .desc_xoff_req(desc_xoff_req),
    .tmr_tick(tmr_tick), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .status_word(status_word), .xoff_req(xoff_req)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_word();
    return (int'(m_plow) << 12) | (int'(m_paused) << 11) | (int'(m_full) << 10) | (int'(m_xoff) << 9);
  endfunction

  task automatic model_update();
    int  nt, mx;
    bit  ld, z, swx, swn;
    ld = rx_pause_vld || rx_plow_vld || tx_pause_vld;
    mx = 0;
    if (rx_pause_vld && rx_pause_val > mx) mx = rx_pause_val;
    if (rx_plow_vld  && rx_plow_val  > mx) mx = rx_plow_val;
    if (tx_pause_vld && tx_pause_val > mx) mx = tx_pause_val;
    if (ld) nt = mx;
    else if (tmr_tick && m_tmr > 0) nt = m_tmr - 1;
    else nt = m_tmr;
    z   = (m_tmr != 0) && (nt == 0);
    swx = reg_wr_en && reg_wr_data[9];
    swn = reg_wr_en && reg_wr_data[8];
    if (rx_plow_vld && rx_plow_val != 0) m_plow = 1; else if (z || rx_pause_vld) m_plow = 0;
    if (rx_pause_vld || rx_plow_vld || fifo_thresh_hit || desc_xoff_req || swx) m_paused = 1;
    else if (z) m_paused = 0;
    if (tx_pause_vld && tx_pause_val != 0) m_full = 1; else if (z) m_full = 0;
    if (swx || desc_xoff_req) m_xoff = 1; else if (swn) m_xoff = 0;
    m_tmr = nt;
  endtask

  // One clock: model follows the edge, inputs return idle, ports compared to model.
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    rx_pause_vld = 0; rx_plow_vld = 0; tx_pause_vld = 0;
    fifo_thresh_hit = 0; desc_xoff_req = 0; reg_wr_en = 0; tmr_tick = 0;
    check("R5 model bit12", status_word[12], m_plow);
    check("R6 model bit11", status_word[11], m_paused);
    check("R7 model bit10", status_word[10], m_full);
    check("R8 model bit9", status_word[9], m_xoff);
    check("R8 model xoff_req", xoff_req, m_xoff);
    check("R2 model others", int'(status_word & 16'hE1FF), 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tmr_tick = 1; step(); end
  endtask

  task automatic rxp(int v);  rx_pause_vld = 1; rx_pause_val = 16'(v); endtask
  task automatic rxl(int v);  rx_plow_vld = 1;  rx_plow_val  = 16'(v); endtask
  task automatic txp(int v);  tx_pause_vld = 1; tx_pause_val = 16'(v); endtask
  task automatic wr(int d);   reg_wr_en = 1;    reg_wr_data  = 16'(d); endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status_word, 16'h0000);
    check("R1 reset xoff_req", xoff_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R5/R6 set by pause-low; R3/R4 count of 3 ticks
    rxl(3); step();  check("R5 plow set", status_word, 16'h1800);
    ticks(2);        check("R3 still counting", status_word, 16'h1800);
    ticks(1);        check("R4 zero clears", status_word, 16'h0000);

    // R7
    txp(0); step();  check("R7 zero tx pause no full", status_word, 16'h0000);
    txp(2); step();  check("R7 full set", status_word, 16'h0400);
    ticks(1);        check("R3 full one tick", status_word, 16'h0400);
    ticks(1);        check("R7 full cleared", status_word, 16'h0000);

    // R2 read-only / reserved writes ignored
    wr(16'hFCFF); step(); check("R2 ro write ignored", status_word, 16'h0000);

    // R8 transmit-off handling
    wr(16'h0200); step(); check("R8 xoff set", status_word, 16'h0A00);
    check("R8 xoff_req high", xoff_req, 1);
    wr(16'h0000); step(); check("R8 write zero keeps xoff", status_word, 16'h0A00);
    ticks(3);             check("R6 paused holds w/o zero evt", status_word, 16'h0A00);
    wr(16'h0100); step(); check("R8 xon clears", status_word, 16'h0800);
    check("R8 xoff_req low", xoff_req, 0);
    rxp(1); step(); ticks(1); check("R4 paused clear", status_word, 16'h0000);

    // R9 xoff and xon together
    wr(16'h0300); step(); check("R9 xoff wins over xon", status_word, 16'h0A00);
    wr(16'h0100); step(); rxp(1); step(); ticks(1);
    check("R9 cleanup", status_word, 16'h0000);

    // R5 cleared by pause frame; R3 reload
    rxl(5); step();  check("R5 plow set again", status_word, 16'h1800);
    rxp(4); step();  check("R5 cleared by pause", status_word, 16'h0800);
    ticks(3);        check("R3 reload counting", status_word, 16'h0800);
    ticks(1);        check("R3 reload expires", status_word, 16'h0000);

    // R3 largest value wins
    rxp(2); txp(6); step(); check("R3 dual load", status_word, 16'h0C00);
    ticks(2);        check("R3 max kept", status_word, 16'h0C00);
    ticks(4);        check("R3 max expires", status_word, 16'h0000);

    // R9 set wins against zero event
    rxp(1); step();
    tmr_tick = 1; fifo_thresh_hit = 1; step();
    check("R9 paused survives zero evt", status_word, 16'h0800);
    rxp(1); step(); ticks(1); check("R9 cleanup2", status_word, 16'h0000);

    // R4 zero-valued load ends the count
    rxp(4); txp(4); step(); ticks(1); check("R4 running", status_word, 16'h0C00);
    txp(0); step();  check("R4 zero load clears", status_word, 16'h0000);

    // R5 zero pause-low
    rxl(0); step();  check("R5 zero plow no bit12", status_word, 16'h0800);
    rxp(1); step(); ticks(1);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) rxp($urandom_range(6));
      if ($urandom_range(15) == 0) rxl($urandom_range(6));
      if ($urandom_range(15) == 0) txp($urandom_range(6));
      fifo_thresh_hit = ($urandom_range(31) == 0);
      desc_xoff_req   = ($urandom_range(47) == 0);
      if ($urandom_range(11) == 0) wr($urandom_range(16'hFFFF));
      tmr_tick = $urandom_range(1);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule